// File: doc/BRIEF.md
# Paired Base Register Address Former

This block holds a small file of eight 24-bit base registers and turns an instruction word into an operand address made of a segment number and an offset within that segment. Each base register is marked either external or internal. An external register names a segment directly. An internal register carries an offset that is added to the instruction's own offset. It also names a partner register, and that partner supplies the segment.

The surrounding pipeline presents a 36-bit instruction word with a valid strobe. One cycle later the block returns the formed address with its own valid strobe. Bit 29 of the word chooses the form. When the bit is clear, the low 18 bits pass through as an absolute-form address. When it is set, the word selects a base register and gives a 15-bit offset. A separate write port loads any base register at a clock edge. Descriptor lookup, paging and the memory access itself happen downstream.

Top module: `abrAddrFormer`

## Requirements
- R1: While rstN is low and after it rises, every base register holds zero, outValid is 0, and outAppend, outSeg, outOffset and outPairErr are all zero until the first valid input.
- R2: When wrEn is high at a rising clock edge, wrData is stored in the base register numbered wrSel. Register layout: bits 17:0 are the address field, bit 21 = 1 marks the register external, and bits 20:18 name the partner register of an internal one.
- R3: With instWord[29] = 0, the result is outAppend = 0, outOffset = instWord[17:0], outSeg = 0 and outPairErr = 0.
- R4: With instWord[29] = 1, instWord[2:0] selects a base register and instWord[17:3] is the offset Y. If that register is external, outSeg is its address field and outOffset is Y zero-extended to 18 bits, with outAppend = 1 and outPairErr = 0.
- R5: If the selected register is internal, outOffset = (Y + its address field) mod 2^18, and outSeg is the address field of the partner register named by its bits 20:18.
- R6: If an internal register names a partner whose bit 21 is clear, including itself, outPairErr = 1 and outSeg = 0, and outOffset still follows R5.
- R7: outValid is high in exactly the cycle after a cycle in which inValid is high.
- R8: In a cycle with no valid input, outAppend, outSeg, outOffset and outPairErr keep their previous values.
- R9: A register write and an address formation at the same edge that touch the same register use the contents from before the write.
- R10: Instruction bits 18 to 28 and 30 to 35 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Base register write enable |
| wrSel | input | 3 | Number of the register to write |
| wrData | input | 24 | Value to write |
| inValid | input | 1 | Instruction word is present |
| instWord | input | 36 | Instruction word |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outAppend | output | 1 | 1 when the result is segment-relative |
| outSeg | output | 18 | Segment number |
| outOffset | output | 18 | Offset within the segment, or absolute address |
| outPairErr | output | 1 | Internal register paired with a non-external one |

## Verification
The assertions assume that inValid and wrEn are clean 0 or 1 levels and that inValid stays low during reset, so the first strobe after reset has a known predecessor. The bench meets this by driving every input only at the falling edge and by holding inValid and wrEn low until reset has been released. The bench then mixes directed pairings with random words, including random values in the ignored instruction fields and random bit 21 on writes. This covers external, internal, bad-pair and absolute cases as well as writes that collide with reads.

// File: rtl/abrPkg.sv
package abrPkg;
  localparam int NUM_BASE = 8;
  localparam int SEL_W    = $clog2(NUM_BASE);
  localparam int ADDR_W   = 18;
  localparam int CTL_W    = 6;
  localparam int REG_W    = ADDR_W + CTL_W;
  localparam int Y_W      = ADDR_W - SEL_W;
  localparam int EXT_BIT  = ADDR_W + SEL_W;
  localparam int INST_W   = 36;
  localparam int MODE_BIT = 29;

  typedef struct packed {
    logic capture;
    logic load;
  } abrStrobe_t;
endpackage

// File: rtl/abrCtl.sv
module abrCtl
  import abrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       wrEn,
  output abrStrobe_t strb,
  output logic       outValid
);
  always_comb begin
    strb.capture = inValid;
    strb.load    = wrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/abrPath.sv
module abrPath
  import abrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  abrStrobe_t        strb,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [REG_W-1:0]  wrData,
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] addrField,
  output logic              outAppend,
  output logic [ADDR_W-1:0] outSeg,
  output logic [ADDR_W-1:0] outOffset,
  output logic              outPairErr
);
  logic [REG_W-1:0] baseReg [NUM_BASE];

  for (genvar g = 0; g < NUM_BASE; g++) begin : gBase
    always_ff @(posedge clk) begin
      if (!rstN)
        baseReg[g] <= '0;
      else if (strb.load && wrSel == SEL_W'(g))
        baseReg[g] <= wrData;
    end
  end

  logic [SEL_W-1:0]  selIdx;
  logic [Y_W-1:0]    yField;
  logic [REG_W-1:0]  selReg;
  logic [SEL_W-1:0]  partnerIdx;
  logic [REG_W-1:0]  partnerReg;
  logic [ADDR_W-1:0] sumOfs;
  logic              nxtAppend;
  logic [ADDR_W-1:0] nxtSeg;
  logic [ADDR_W-1:0] nxtOfs;
  logic              nxtErr;

  always_comb begin
    selIdx     = addrField[SEL_W-1:0];
    yField     = addrField[ADDR_W-1:SEL_W];
    selReg     = baseReg[selIdx];
    partnerIdx = selReg[ADDR_W +: SEL_W];
    partnerReg = baseReg[partnerIdx];
    sumOfs     = {{SEL_W{1'b0}}, yField} + selReg[ADDR_W-1:0];

    nxtAppend = modeSel;
    nxtSeg    = '0;
    nxtOfs    = addrField;
    nxtErr    = 1'b0;
    if (modeSel) begin
      if (selReg[EXT_BIT]) begin
        nxtSeg = selReg[ADDR_W-1:0];
        nxtOfs = {{SEL_W{1'b0}}, yField};
      end else begin
        nxtOfs = sumOfs;
        if (partnerReg[EXT_BIT]) nxtSeg = partnerReg[ADDR_W-1:0];
        else                     nxtErr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAppend  <= 1'b0;
      outSeg     <= '0;
      outOffset  <= '0;
      outPairErr <= 1'b0;
    end else if (strb.capture) begin
      outAppend  <= nxtAppend;
      outSeg     <= nxtSeg;
      outOffset  <= nxtOfs;
      outPairErr <= nxtErr;
    end
  end
endmodule

// File: rtl/abrAddrFormer.sv
module abrAddrFormer
  import abrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [REG_W-1:0]  wrData,
  input  logic              inValid,
  input  logic [INST_W-1:0] instWord,
  output logic              outValid,
  output logic              outAppend,
  output logic [ADDR_W-1:0] outSeg,
  output logic [ADDR_W-1:0] outOffset,
  output logic              outPairErr
);
  abrStrobe_t strb;

  abrCtl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .wrEn     (wrEn),
    .strb     (strb),
    .outValid (outValid)
  );

  abrPath uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrSel      (wrSel),
    .wrData     (wrData),
    .modeSel    (instWord[MODE_BIT]),
    .addrField  (instWord[ADDR_W-1:0]),
    .outAppend  (outAppend),
    .outSeg     (outSeg),
    .outOffset  (outOffset),
    .outPairErr (outPairErr)
  );
endmodule

// File: rtl/abrAddrFormerChk.sv
module abrAddrFormerChk
  import abrPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              outValid,
  input logic              outAppend,
  input logic [ADDR_W-1:0] outSeg,
  input logic [ADDR_W-1:0] outOffset,
  input logic              outPairErr
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  a_r6_err_zero_seg: assert property (@(posedge clk) disable iff (!rstN)
    outPairErr |-> (outSeg == '0 && outAppend));

  a_r3_absolute_clean: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outAppend) |-> (outSeg == '0 && !outPairErr));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(inValid) && $past(rstN)) |->
      ($stable(outSeg) && $stable(outOffset) && $stable(outAppend) && $stable(outPairErr)));
endmodule

bind abrAddrFormer abrAddrFormerChk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .outValid   (outValid),
  .outAppend  (outAppend),
  .outSeg     (outSeg),
  .outOffset  (outOffset),
  .outPairErr (outPairErr)
);

// File: tb/tb_abrAddrFormer.sv
module tb_abrAddrFormer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [23:0] wrData = '0;
  logic        inValid = 1'b0;
  logic [35:0] instWord = '0;
  logic        outValid;
  logic        outAppend;
  logic [17:0] outSeg;
  logic [17:0] outOffset;
  logic        outPairErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  abrAddrFormer dut (.*);

  // behavioural reference state
  int        mReg [8];
  bit        eValid = 0, eAppend = 0, eErr = 0;
  int        eSeg = 0, eOfs = 0;
  string     eTag = "R1";

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: model the edge, then compare at the falling edge
  task automatic tick();
    int sel, y, r, p;
    @(posedge clk);
    if (rstN) begin
      eValid = inValid;
      if (inValid) begin
        if (!instWord[29]) begin
          eAppend = 0; eSeg = 0; eOfs = int'(instWord[17:0]); eErr = 0; eTag = "R3/R10";
        end else begin
          sel = int'(instWord[2:0]);
          y   = int'(instWord[17:3]);
          r   = mReg[sel];
          eAppend = 1;
          if (r[21]) begin
            eSeg = r & 'h3FFFF; eOfs = y; eErr = 0; eTag = "R4";
          end else begin
            eOfs = (y + (r & 'h3FFFF)) % (1 << 18);
            p = mReg[(r >> 18) & 7];
            if (p[21]) begin eSeg = p & 'h3FFFF; eErr = 0; eTag = "R5"; end
            else begin eSeg = 0; eErr = 1; eTag = "R6"; end
          end
        end
      end else eTag = "R8";
      if (wrEn) mReg[wrSel] = int'(wrData);
    end
    @(negedge clk);
    chk("R7 outValid", int'(outValid), int'(eValid));
    chk({eTag, " outAppend"}, int'(outAppend), int'(eAppend));
    chk({eTag, " outSeg"}, int'(outSeg), eSeg);
    chk({eTag, " outOffset"}, int'(outOffset), eOfs);
    chk({eTag, " outPairErr"}, int'(outPairErr), int'(eErr));
  endtask

  task automatic wr(input int sel, input int data);
    wrEn = 1; wrSel = 3'(sel); wrData = 24'(data); inValid = 0;
    tick();
    wrEn = 0;
  endtask

  task automatic issue(input bit app, input int sel, input int y, input int abs18);
    inValid = 1;
    instWord = {$urandom(), $urandom()};
    instWord[29] = app;
    if (app) begin instWord[2:0] = 3'(sel); instWord[17:3] = 15'(y); end
    else instWord[17:0] = 18'(abs18);
    tick();
    inValid = 0;
  endtask

  function automatic int extReg(input int seg);
    return (1 << 21) | (seg & 'h3FFFF);
  endfunction

  function automatic int intReg(input int partner, input int ofs);
    return ((partner & 7) << 18) | (ofs & 'h3FFFF);
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) mReg[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 outSeg", int'(outSeg), 0);
    chk("R1 outOffset", int'(outOffset), 0);
    rstN = 1;
    tick();
    // R1/R6: cleared registers are internal, paired with register 0
    issue(1, 3, 'h12, 0);
    // R3 absolute form
    issue(0, 0, 0, 'h2ABCD);
    tick(); tick(); // R8 hold
    // R2 writes: pair 0 internal -> 1 external, 2 external, 4 internal -> 5
    wr(1, extReg('h1F00F));
    wr(0, intReg(1, 'h00100));
    wr(2, extReg('h3FFFF));
    wr(5, extReg('h00042));
    wr(4, intReg(5, 'h3FFFF));
    issue(1, 1, 'h7FFF, 0);         // R4
    issue(1, 0, 'h0010, 0);         // R5
    issue(1, 4, 'h7FFF, 0);         // R5 wrap
    issue(1, 4, 0, 0);              // R5 wrap at 0x3FFFF
    // R6: internal naming internal partner, and itself
    wr(6, intReg(0, 'h5));
    issue(1, 6, 'h3, 0);
    wr(7, intReg(7, 'h10));
    issue(1, 7, 'h1, 0);
    // R9: write and read of register 1 in same cycle
    wrEn = 1; wrSel = 3'd1; wrData = 24'(extReg('h00777));
    issue(1, 1, 'h5, 0);
    wrEn = 0;
    issue(1, 1, 'h5, 0);
    // R9: write partner while internal reads it
    wrEn = 1; wrSel = 3'd5; wrData = 24'(intReg(0, 0));
    issue(1, 4, 'h1, 0);
    wrEn = 0;
    issue(1, 4, 'h1, 0);
    // random mix (R2..R10)
    for (int n = 0; n < 3000; n++) begin
      wrEn = ($urandom % 4) == 0;
      wrSel = 3'($urandom);
      wrData = 24'($urandom);
      inValid = ($urandom % 3) != 0;
      instWord = {$urandom(), $urandom()};
      tick();
    end
    wrEn = 0; inValid = 0;
    tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule